// File: doc/BRIEF.md
# Execute-Stage Control Sequencer

This block is the control unit for the execute stage of a three-stage (fetch, decode, execute) 32-bit core. It takes a pre-decoded instruction record from the decode stage and drives the datapath selects that the record needs, one control word per clock: register-bank read addresses, operand-B source and immediate value, shift amount, ALU operation, the source of the memory address register, register and PC write enables, and the write-back source. Data processing records finish in one execute cycle. Loads, stores and branches step through fixed multi-cycle sequences of their own.

While a multi-cycle record is in execute, the sequencer asks fetch and decode to hold. A branch loads its target into the PC, flags the two younger pipe entries as invalid, saves the return address into the link register, and then corrects it during the refill cycle. A memory-ready input freezes the sequence in place while the memory is not ready.

Record encodings: class 0 = register data op, 1 = immediate data op, 2 = load/store, 3 = branch. ALU operation codes: 0 = add, 1 = subtract, 2 = pass operand A, 3 = pass operand B. The PC is register 15 and the link register is register 14.

Top module: `exec_sequencer`

## Requirements
- R1: After reset no record is in execute, and the output word is the idle word: `pc_inc`=1 and every other output 0.
- R2: In every cycle, an output field that is not named for that cycle in R3 to R12 is 0.
- R3: With `mem_ready`=1 and execute empty or in the last cycle of its record, the record on the decode inputs enters execute at the clock edge if `dec_valid`=1. If `dec_valid`=0, execute becomes empty and shows the idle word.
- R4: A class 0 record takes one cycle: `rf_ra`=Rn, `rf_rb`=Rm, `alu_op`=the record's op, `rf_we`=1 to Rd, `pc_inc`=1, `hold`=0. Back-to-back class 0 records give one new control word per cycle.
- R5: A class 1 record takes one cycle: as R4, but `rf_rb`=0, `opb_imm`=1 and `imm_val` is the low 8 bits of the field, zero-extended.
- R6: Cycle 1 of a class 2 record: `rf_ra`=Rn, `opb_imm`=1, `imm_val`=low 12 bits of the field zero-extended, `sh_amt`=0, `alu_op`=add when up=1 and subtract when up=0, `addr_sel`=1, `hold`=1, `pc_inc`=0.
- R7: Cycle 2 of a store (load=0) is its last: `rf_rb`=Rd, `dout_en`=1, `pc_inc`=1, `hold`=0. With writeback=1 it also sets `rf_ra`=Rn, `opb_imm`=1, the same offset and ALU op as R6, and `rf_we`=1 to Rn.
- R8: Cycle 2 of a load has `hold`=1, `pc_inc`=0, `dout_en`=0 and the same writeback fields as R7. Cycle 3 sets `rf_we`=1 to Rd with `wr_src`=1 (data-in) and `pc_inc`=1.
- R9: Cycle 1 of a branch: `rf_ra`=15, `opb_imm`=1, `imm_val`=the 24-bit field sign-extended, `sh_amt`=2, `alu_op`=add, `pc_we`=1, `addr_sel`=1, `squash`=1, `pc_inc`=0.
- R10: Cycle 2 of a branch: `rf_ra`=15, `alu_op`=pass A, `rf_we`=1 to register 14, `pc_inc`=1.
- R11: Cycle 3 of a branch: `rf_ra`=14, `opb_imm`=1, `imm_val`=4, `sh_amt`=0, `alu_op`=subtract, `rf_we`=1 to register 14, `pc_inc`=1.
- R12: While `mem_ready`=0, the sequencer state does not change, `rf_we`, `pc_we`, `pc_inc` and `squash` are 0, `hold` is 1, and the other fields keep the values of the current cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_ready | input | 1 | Memory ready; low freezes the sequencer |
| dec_valid | input | 1 | Decode record is valid |
| dec_class | input | 2 | Instruction class |
| dec_op | input | 2 | ALU operation for data ops |
| dec_rd | input | 4 | Destination / store-data register |
| dec_rn | input | 4 | First source / base register |
| dec_rm | input | 4 | Second source register |
| dec_field | input | 24 | Immediate, offset or branch displacement field |
| dec_load | input | 1 | 1 = load, 0 = store |
| dec_up | input | 1 | 1 = add offset, 0 = subtract |
| dec_wb | input | 1 | Write the updated base back to Rn |
| rf_ra | output | 4 | Read port A address |
| rf_rb | output | 4 | Read port B address |
| opb_imm | output | 1 | Operand B from `imm_val` instead of port B |
| imm_val | output | 32 | Immediate operand |
| sh_amt | output | 5 | Left-shift amount applied to operand B |
| alu_op | output | 2 | ALU operation |
| addr_sel | output | 1 | Address register loads the ALU result (1) or the PC incrementer (0) |
| rf_we | output | 1 | Register write enable |
| rf_wa | output | 4 | Register write address |
| wr_src | output | 1 | Write data from data-in register (1) or ALU (0) |
| dout_en | output | 1 | Drive store data out |
| pc_we | output | 1 | PC port loads the ALU result |
| pc_inc | output | 1 | PC advances to the next fetch |
| hold | output | 1 | Fetch and decode keep their contents |
| squash | output | 1 | Invalidate the two younger pipe entries |

## Verification
A back-to-back run of register data ops with all four ALU codes shows whether a new word appears every cycle, and immediate ops with high field bits set tell the 8-bit mask from the 12-bit one. Loads and stores are tried with up and down offsets and with writeback on and off, which separates the store's two-cycle sequence from the load's three and the base update from its absence. Branches with positive and negative displacements tell sign extension from zero extension and check the link save and fix-up order. The same mixed program is then rerun with `mem_ready` dropped on an irregular pattern and with empty decode slots between records, which shows freezing and the accept point apart.

// File: rtl/seq_pkg.sv
package seq_pkg;
  parameter int XLEN       = 32;
  parameter int RIDX_W     = 4;
  parameter int SH_W       = 5;
  parameter int DIMM_W     = 8;
  parameter int MOFF_W     = 12;
  parameter int BOFF_W     = 24;
  parameter int BR_SHIFT   = 2;
  parameter int INSN_BYTES = 4;
  parameter int STEP_W     = 2;

  localparam logic [RIDX_W-1:0] PC_REG   = RIDX_W'(15);
  localparam logic [RIDX_W-1:0] LINK_REG = RIDX_W'(14);
  localparam logic [XLEN-1:0]   LINK_FIX = XLEN'(INSN_BYTES);

  typedef enum logic [1:0] {CL_DPR, CL_DPI, CL_MEM, CL_BR} cls_e;
  typedef enum logic [1:0] {OP_ADD, OP_SUB, OP_PASSA, OP_PASSB} alu_e;

  typedef struct packed {
    cls_e              cls;
    alu_e              op;
    logic [RIDX_W-1:0] rd;
    logic [RIDX_W-1:0] rn;
    logic [RIDX_W-1:0] rm;
    logic [BOFF_W-1:0] field;
    logic              ld;
    logic              up;
    logic              wb;
  } rec_t;

  typedef struct packed {
    logic [RIDX_W-1:0] ra;
    logic [RIDX_W-1:0] rb;
    logic              opb_imm;
    logic [XLEN-1:0]   imm;
    logic [SH_W-1:0]   sh;
    alu_e              alu;
    logic              addr_sel;
    logic              rf_we;
    logic [RIDX_W-1:0] wa;
    logic              wr_src;
    logic              dout_en;
    logic              pc_we;
    logic              pc_inc;
    logic              hold;
    logic              squash;
  } ctrl_t;

  function automatic logic [XLEN-1:0] dp_imm(input logic [BOFF_W-1:0] f);
    return XLEN'(f[DIMM_W-1:0]);
  endfunction

  function automatic logic [XLEN-1:0] mem_off(input logic [BOFF_W-1:0] f);
    return XLEN'(f[MOFF_W-1:0]);
  endfunction

  function automatic logic [XLEN-1:0] br_off(input logic [BOFF_W-1:0] f);
    return {{(XLEN-BOFF_W){f[BOFF_W-1]}}, f};
  endfunction

  function automatic alu_e dir_op(input logic up);
    return up ? OP_ADD : OP_SUB;
  endfunction

  function automatic logic [STEP_W-1:0] final_step(input rec_t r);
    case (r.cls)
      CL_MEM:  return r.ld ? STEP_W'(2) : STEP_W'(1);
      CL_BR:   return STEP_W'(2);
      default: return STEP_W'(0);
    endcase
  endfunction
endpackage

// File: rtl/seq_state.sv
module seq_state
  import seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_ready,
  input  logic              last,
  input  logic              dec_valid,
  input  rec_t              dec_rec,
  output logic              ex_valid,
  output rec_t              ex_rec,
  output logic [STEP_W-1:0] step
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ex_valid <= 1'b0;
      ex_rec   <= '0;
      step     <= '0;
    end else if (mem_ready) begin
      if (last) begin
        ex_valid <= dec_valid;
        ex_rec   <= dec_rec;
        step     <= '0;
      end else begin
        step <= step + STEP_W'(1);
      end
    end
  end
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
(
  input  logic              ex_valid,
  input  rec_t              ex_rec,
  input  logic [STEP_W-1:0] step,
  output ctrl_t             cw,
  output logic              last
);
  always_comb begin
    cw   = '0;
    last = 1'b1;
    if (!ex_valid) begin
      cw.pc_inc = 1'b1;
    end else begin
      last = (step == final_step(ex_rec));
      case (ex_rec.cls)
        CL_DPR: begin
          cw.ra     = ex_rec.rn;
          cw.rb     = ex_rec.rm;
          cw.alu    = ex_rec.op;
          cw.rf_we  = 1'b1;
          cw.wa     = ex_rec.rd;
          cw.pc_inc = 1'b1;
        end
        CL_DPI: begin
          cw.ra      = ex_rec.rn;
          cw.opb_imm = 1'b1;
          cw.imm     = dp_imm(ex_rec.field);
          cw.alu     = ex_rec.op;
          cw.rf_we   = 1'b1;
          cw.wa      = ex_rec.rd;
          cw.pc_inc  = 1'b1;
        end
        CL_MEM: begin
          if (step == STEP_W'(0)) begin
            cw.ra       = ex_rec.rn;
            cw.opb_imm  = 1'b1;
            cw.imm      = mem_off(ex_rec.field);
            cw.alu      = dir_op(ex_rec.up);
            cw.addr_sel = 1'b1;
            cw.hold     = 1'b1;
          end else if (step == STEP_W'(1)) begin
            cw.rb      = ex_rec.ld ? '0 : ex_rec.rd;
            cw.dout_en = !ex_rec.ld;
            cw.hold    = ex_rec.ld;
            cw.pc_inc  = !ex_rec.ld;
            if (ex_rec.wb) begin
              cw.ra      = ex_rec.rn;
              cw.opb_imm = 1'b1;
              cw.imm     = mem_off(ex_rec.field);
              cw.alu     = dir_op(ex_rec.up);
              cw.rf_we   = 1'b1;
              cw.wa      = ex_rec.rn;
            end
          end else begin
            cw.rf_we  = 1'b1;
            cw.wa     = ex_rec.rd;
            cw.wr_src = 1'b1;
            cw.pc_inc = 1'b1;
          end
        end
        default: begin
          if (step == STEP_W'(0)) begin
            cw.ra       = PC_REG;
            cw.opb_imm  = 1'b1;
            cw.imm      = br_off(ex_rec.field);
            cw.sh       = SH_W'(BR_SHIFT);
            cw.alu      = OP_ADD;
            cw.pc_we    = 1'b1;
            cw.addr_sel = 1'b1;
            cw.squash   = 1'b1;
          end else if (step == STEP_W'(1)) begin
            cw.ra     = PC_REG;
            cw.alu    = OP_PASSA;
            cw.rf_we  = 1'b1;
            cw.wa     = LINK_REG;
            cw.pc_inc = 1'b1;
          end else begin
            cw.ra      = LINK_REG;
            cw.opb_imm = 1'b1;
            cw.imm     = LINK_FIX;
            cw.alu     = OP_SUB;
            cw.rf_we   = 1'b1;
            cw.wa      = LINK_REG;
            cw.pc_inc  = 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/seq_gate.sv
module seq_gate
  import seq_pkg::*;
(
  input  logic  mem_ready,
  input  ctrl_t raw,
  output ctrl_t gated
);
  always_comb begin
    gated = raw;
    if (!mem_ready) begin
      gated.rf_we  = 1'b0;
      gated.pc_we  = 1'b0;
      gated.pc_inc = 1'b0;
      gated.squash = 1'b0;
      gated.hold   = 1'b1;
    end
  end
endmodule

// File: rtl/exec_sequencer.sv
module exec_sequencer
  import seq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mem_ready,
  input  logic                 dec_valid,
  input  logic [1:0]           dec_class,
  input  logic [1:0]           dec_op,
  input  logic [RIDX_W-1:0]    dec_rd,
  input  logic [RIDX_W-1:0]    dec_rn,
  input  logic [RIDX_W-1:0]    dec_rm,
  input  logic [BOFF_W-1:0]    dec_field,
  input  logic                 dec_load,
  input  logic                 dec_up,
  input  logic                 dec_wb,
  output logic [RIDX_W-1:0]    rf_ra,
  output logic [RIDX_W-1:0]    rf_rb,
  output logic                 opb_imm,
  output logic [XLEN-1:0]      imm_val,
  output logic [SH_W-1:0]      sh_amt,
  output logic [1:0]           alu_op,
  output logic                 addr_sel,
  output logic                 rf_we,
  output logic [RIDX_W-1:0]    rf_wa,
  output logic                 wr_src,
  output logic                 dout_en,
  output logic                 pc_we,
  output logic                 pc_inc,
  output logic                 hold,
  output logic                 squash
);
  rec_t              dec_rec;
  rec_t              ex_rec;
  logic              ex_valid;
  logic [STEP_W-1:0] ex_step;
  logic              last_cycle;
  logic              ex_is_br;
  ctrl_t             raw_cw;
  ctrl_t             out_cw;

  always_comb begin
    dec_rec.cls   = cls_e'(dec_class);
    dec_rec.op    = alu_e'(dec_op);
    dec_rec.rd    = dec_rd;
    dec_rec.rn    = dec_rn;
    dec_rec.rm    = dec_rm;
    dec_rec.field = dec_field;
    dec_rec.ld    = dec_load;
    dec_rec.up    = dec_up;
    dec_rec.wb    = dec_wb;
  end

  seq_state u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_ready(mem_ready),
    .last     (last_cycle),
    .dec_valid(dec_valid),
    .dec_rec  (dec_rec),
    .ex_valid (ex_valid),
    .ex_rec   (ex_rec),
    .step     (ex_step)
  );

  seq_ctrl u_ctrl (
    .ex_valid(ex_valid),
    .ex_rec  (ex_rec),
    .step    (ex_step),
    .cw      (raw_cw),
    .last    (last_cycle)
  );

  seq_gate u_gate (
    .mem_ready(mem_ready),
    .raw      (raw_cw),
    .gated    (out_cw)
  );

  assign ex_is_br = ex_valid && (ex_rec.cls == CL_BR);

  assign rf_ra    = out_cw.ra;
  assign rf_rb    = out_cw.rb;
  assign opb_imm  = out_cw.opb_imm;
  assign imm_val  = out_cw.imm;
  assign sh_amt   = out_cw.sh;
  assign alu_op   = out_cw.alu;
  assign addr_sel = out_cw.addr_sel;
  assign rf_we    = out_cw.rf_we;
  assign rf_wa    = out_cw.wa;
  assign wr_src   = out_cw.wr_src;
  assign dout_en  = out_cw.dout_en;
  assign pc_we    = out_cw.pc_we;
  assign pc_inc   = out_cw.pc_inc;
  assign hold     = out_cw.hold;
  assign squash   = out_cw.squash;
endmodule

// File: rtl/seq_checker.sv
module seq_checker
  import seq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              mem_ready,
  input logic [RIDX_W-1:0] rf_ra,
  input logic [RIDX_W-1:0] rf_wa,
  input logic [XLEN-1:0]   imm_val,
  input logic [SH_W-1:0]   sh_amt,
  input logic [1:0]        alu_op,
  input logic              addr_sel,
  input logic              rf_we,
  input logic              pc_we,
  input logic              pc_inc,
  input logic              hold,
  input logic              squash,
  input logic              ex_is_br,
  input logic [STEP_W-1:0] ex_step
);
  p_freeze_outputs_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ready |-> (!rf_we && !pc_we && !pc_inc && !squash && hold));

  p_freeze_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ready |=> (ex_step == $past(ex_step)));

  p_step_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ex_step <= STEP_W'(2));

  p_pc_single_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pc_we, pc_inc}));

  p_squash_on_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
    squash |-> (pc_we && sh_amt == SH_W'(BR_SHIFT)));

  p_link_save_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we |=> (!mem_ready || (rf_we && rf_wa == LINK_REG && rf_ra == PC_REG)));

  p_link_fix_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_is_br && ex_step == STEP_W'(1) && mem_ready) |=>
      (!mem_ready || (alu_op == 2'(OP_SUB) && rf_wa == LINK_REG && imm_val == LINK_FIX)));

  p_addr_cycle_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_sel && !ex_is_br) |-> hold);
endmodule

bind exec_sequencer seq_checker i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mem_ready(mem_ready),
  .rf_ra    (rf_ra),
  .rf_wa    (rf_wa),
  .imm_val  (imm_val),
  .sh_amt   (sh_amt),
  .alu_op   (alu_op),
  .addr_sel (addr_sel),
  .rf_we    (rf_we),
  .pc_we    (pc_we),
  .pc_inc   (pc_inc),
  .hold     (hold),
  .squash   (squash),
  .ex_is_br (ex_is_br),
  .ex_step  (ex_step)
);

// File: tb/test_exec_sequencer.sv
module test_exec_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_ready = 1'b1;
  logic        dec_valid = 1'b0;
  logic [1:0]  dec_class = '0;
  logic [1:0]  dec_op = '0;
  logic [3:0]  dec_rd = '0, dec_rn = '0, dec_rm = '0;
  logic [23:0] dec_field = '0;
  logic        dec_load = 1'b0, dec_up = 1'b0, dec_wb = 1'b0;
  logic [3:0]  rf_ra, rf_rb, rf_wa;
  logic        opb_imm, addr_sel, rf_we, wr_src, dout_en, pc_we, pc_inc, hold, squash;
  logic [31:0] imm_val;
  logic [4:0]  sh_amt;
  logic [1:0]  alu_op;

  always #10 clk = ~clk;

  exec_sequencer i_exec_sequencer (
    .clk(clk), .rst_n(rst_n), .mem_ready(mem_ready), .dec_valid(dec_valid),
    .dec_class(dec_class), .dec_op(dec_op), .dec_rd(dec_rd), .dec_rn(dec_rn),
    .dec_rm(dec_rm), .dec_field(dec_field), .dec_load(dec_load), .dec_up(dec_up),
    .dec_wb(dec_wb), .rf_ra(rf_ra), .rf_rb(rf_rb), .opb_imm(opb_imm),
    .imm_val(imm_val), .sh_amt(sh_amt), .alu_op(alu_op), .addr_sel(addr_sel),
    .rf_we(rf_we), .rf_wa(rf_wa), .wr_src(wr_src), .dout_en(dout_en),
    .pc_we(pc_we), .pc_inc(pc_inc), .hold(hold), .squash(squash)
  );

  typedef struct {
    int ra, rb, opb, imm, sh, alu, addr, we, wa, src, dout, pcwe, pcinc, hld, sq;
    string tag;
  } cw_t;

  typedef struct {
    bit v; int cls, op, rd, rn, rm, field; bit ld, up, wb;
  } pe_t;

  cw_t   script[$];
  pe_t   prog[$];
  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  bit    finished = 0;

  function automatic cw_t mk(int ra, int rb, int opb, int imm, int sh, int alu, int addr,
                             int we, int wa, int src, int dout, int pcwe, int pcinc,
                             int hld, int sq, string tag);
    cw_t c;
    c.ra = ra; c.rb = rb; c.opb = opb; c.imm = imm; c.sh = sh; c.alu = alu;
    c.addr = addr; c.we = we; c.wa = wa; c.src = src; c.dout = dout;
    c.pcwe = pcwe; c.pcinc = pcinc; c.hld = hld; c.sq = sq; c.tag = tag;
    return c;
  endfunction

  function automatic logic [59:0] pack(cw_t c);
    return {4'(c.ra), 4'(c.rb), 1'(c.opb), 32'(c.imm), 5'(c.sh), 2'(c.alu), 1'(c.addr),
            1'(c.we), 4'(c.wa), 1'(c.src), 1'(c.dout), 1'(c.pcwe), 1'(c.pcinc),
            1'(c.hld), 1'(c.sq)};
  endfunction

  // Expected per-cycle words for one record, written from R4..R11 (R2: all else 0)
  function automatic void build(pe_t p);
    int off12, sdisp, bwr, bra, bopb, bimm, balu;
    off12 = p.field % 4096;
    balu  = p.up ? 0 : 1;
    case (p.cls)
      0: script.push_back(mk(p.rn, p.rm, 0, 0, 0, p.op, 0, 1, p.rd, 0, 0, 0, 1, 0, 0, "R4"));
      1: script.push_back(mk(p.rn, 0, 1, p.field % 256, 0, p.op, 0, 1, p.rd, 0, 0, 0, 1, 0, 0, "R5"));
      2: begin
        script.push_back(mk(p.rn, 0, 1, off12, 0, balu, 1, 0, 0, 0, 0, 0, 0, 1, 0, "R6"));
        bwr  = p.wb ? 1 : 0;
        bra  = p.wb ? p.rn : 0;
        bopb = p.wb ? 1 : 0;
        bimm = p.wb ? off12 : 0;
        if (!p.wb) balu = 0;
        if (!p.ld) begin
          script.push_back(mk(bra, p.rd, bopb, bimm, 0, balu, 0, bwr, bra, 0, 1, 0, 1, 0, 0, "R7"));
        end else begin
          script.push_back(mk(bra, 0, bopb, bimm, 0, balu, 0, bwr, bra, 0, 0, 0, 0, 1, 0, "R8"));
          script.push_back(mk(0, 0, 0, 0, 0, 0, 0, 1, p.rd, 1, 0, 0, 1, 0, 0, "R8"));
        end
      end
      default: begin
        sdisp = (p.field >= (1 << 23)) ? p.field - (1 << 24) : p.field;
        script.push_back(mk(15, 0, 1, sdisp, 2, 0, 1, 0, 0, 0, 0, 1, 0, 0, 1, "R9"));
        script.push_back(mk(15, 0, 0, 0, 0, 2, 0, 1, 14, 0, 0, 0, 1, 0, 0, "R10"));
        script.push_back(mk(14, 0, 1, 4, 0, 1, 0, 1, 14, 0, 0, 0, 1, 0, 0, "R11"));
      end
    endcase
  endfunction

  task automatic add_rec(int cls, int op, int rd, int rn, int rm, int field, bit ld, bit up, bit wb);
    pe_t p;
    p.v = 1; p.cls = cls; p.op = op; p.rd = rd; p.rn = rn; p.rm = rm;
    p.field = field; p.ld = ld; p.up = up; p.wb = wb;
    prog.push_back(p);
  endtask

  task automatic add_gap();
    pe_t p;
    p.v = 0; p.cls = 0; p.op = 0; p.rd = 0; p.rn = 0; p.rm = 0;
    p.field = 0; p.ld = 0; p.up = 0; p.wb = 0;
    prog.push_back(p);
  endtask

  // One cycle: drive at negedge, compare mid-low, then model the coming edge
  task automatic one_cycle(bit rdy, string idle_tag);
    cw_t e;
    logic [59:0] act, exp;
    @(negedge clk);
    cyc++;
    mem_ready = rdy;
    if (prog.size() > 0) begin
      dec_valid = prog[0].v;        dec_class = 2'(prog[0].cls);
      dec_op    = 2'(prog[0].op);   dec_rd    = 4'(prog[0].rd);
      dec_rn    = 4'(prog[0].rn);   dec_rm    = 4'(prog[0].rm);
      dec_field = 24'(prog[0].field);
      dec_load  = prog[0].ld; dec_up = prog[0].up; dec_wb = prog[0].wb;
    end else begin
      dec_valid = 0; dec_class = '0; dec_op = '0; dec_rd = '0; dec_rn = '0;
      dec_rm = '0; dec_field = '0; dec_load = 0; dec_up = 0; dec_wb = 0;
    end
    #5;
    if (script.size() > 0) e = script[0];
    else e = mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, idle_tag);
    if (!rdy) begin
      e.we = 0; e.pcwe = 0; e.pcinc = 0; e.sq = 0; e.hld = 1;
      e.tag = {e.tag, ",R12"};
    end
    exp = pack(e);
    act = {rf_ra, rf_rb, opb_imm, imm_val, sh_amt, alu_op, addr_sel, rf_we, rf_wa,
           wr_src, dout_en, pc_we, pc_inc, hold, squash};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s,R2 cycle %0d act=%h exp=%h", e.tag, cyc, act, exp);
    end
    if (rdy) begin
      if (script.size() > 0) void'(script.pop_front());
      if (script.size() == 0 && prog.size() > 0) begin
        pe_t p;
        p = prog.pop_front();
        if (p.v) build(p);
      end
    end
  endtask

  task automatic run(int mode);
    int guard = 0;
    while ((prog.size() > 0 || script.size() > 0) && guard < 2000) begin
      bit rdy;
      rdy = (mode == 0) ? 1'b1 : (((cyc * 7 + 3) % 5) != 0 && (cyc % 11) != 4);
      one_cycle(rdy, "R3");
      guard++;
    end
    one_cycle(1'b1, "R3");
  endtask

  task automatic load_mix();
    add_rec(2, 0, 3, 4, 0, 24'hFFF123, 0, 1, 1);   // store up, writeback
    add_rec(2, 0, 5, 6, 0, 24'h000ABC, 1, 0, 0);   // load down, no writeback
    add_gap();
    add_rec(3, 0, 0, 0, 0, 24'h800010, 0, 0, 0);   // branch, negative displacement
    add_rec(0, 3, 9, 1, 2, 0, 0, 0, 0);
    add_rec(2, 0, 7, 8, 0, 24'h000FFF, 1, 1, 1);   // load up, writeback
    add_gap();
    add_gap();
    add_rec(1, 1, 10, 11, 0, 24'h123456, 0, 0, 0);
    add_rec(2, 0, 12, 13, 0, 24'h000001, 0, 0, 0); // store down, no writeback
    add_rec(3, 0, 0, 0, 0, 24'h000040, 0, 0, 0);   // branch, positive displacement
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: idle word straight after reset, with and without a stalled memory
    one_cycle(1'b1, "R1");
    one_cycle(1'b0, "R1");
    one_cycle(1'b1, "R3");
    // R4: back-to-back register ops, all four ALU codes
    add_rec(0, 0, 1, 2, 3, 0, 0, 0, 0);
    add_rec(0, 1, 4, 5, 6, 0, 0, 0, 0);
    add_rec(0, 2, 7, 8, 9, 0, 0, 0, 0);
    add_rec(0, 3, 10, 11, 12, 0, 0, 0, 0);
    run(0);
    // R5: immediate ops with high field bits set
    add_rec(1, 0, 2, 3, 15, 24'hABCDEF, 0, 0, 0);
    add_rec(1, 2, 14, 13, 0, 24'h0000FF, 0, 0, 0);
    run(0);
    // R6, R7, R8: stores and loads, both directions, writeback on and off
    add_rec(2, 0, 1, 2, 0, 24'h000345, 0, 1, 1);
    add_rec(2, 0, 3, 4, 0, 24'h000800, 0, 0, 0);
    add_rec(2, 0, 5, 6, 0, 24'h777001, 1, 1, 0);
    add_rec(2, 0, 7, 8, 0, 24'h000FFE, 1, 0, 1);
    run(0);
    // R9, R10, R11: branches with positive and negative displacement
    add_rec(3, 0, 0, 0, 0, 24'h000003, 0, 0, 0);
    add_rec(3, 0, 0, 0, 0, 24'hFFFFFE, 0, 0, 0);
    add_rec(0, 0, 1, 1, 1, 0, 0, 0, 0);
    run(0);
    // R3: mixed program with empty decode slots
    load_mix();
    run(0);
    // R12: the same program with memory stalls
    load_mix();
    run(1);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule